// File: doc/BRIEF.md
# Locality-Aware Warp Throttling Scheduler

This block picks one warp per cycle to issue from a pool of resident warps. It also limits which warps may issue loads, so that warps which keep losing their own cached lines to thrashing can hold on to their working sets. Each warp has a small victim tag store. The store records the tags of L1 lines that were evicted while that warp owned them. When the same warp later misses on a tag still held in its own store, it has lost locality it had earned, and its lost-locality score rises.

The scores decay by one each cycle. From the scores the block forms a load cap: warps are ranked by score, highest first, and a warp may issue loads only while the scores ranked ahead of it add up to less than a cutoff. A warp that is cut off can still issue non-memory instructions. Among the warps that are eligible this cycle, a round-robin pointer selects one and grants it.

The L1 data array and memory timing sit outside this block. It sees only eviction and miss events, each carrying a warp index and a tag. At most one eviction and one miss arrive per cycle.

Top module: `warp_throttle_sched`

## Requirements
- R1: Each warp keeps its own victim tag store of VT_DEPTH (default 4) entries in first-in-first-out order. An eviction for warp w inserts its tag into w's store only. When the store is full, the oldest tag is dropped, so after five evictions to a 4-entry store the first tag no longer matches.
- R2: A miss by warp w whose tag matches a valid entry in w's own store is a victim hit. On the next cycle w's score becomes max(s-1,0)+32, saturating at 2^SCORE_W-1 (1023 by default). A miss by another warp on the same tag has no effect on w.
- R3: Without a victim hit, a score falls by 1 per cycle and stays at 0 once it reaches 0.
- R4: Warps are ranked by score, highest first, with ties broken toward the lower warp index. Bit i of `load_allowed` is 1 exactly when the scores of all warps ranked ahead of warp i add up to less than 256. The top-ranked warp therefore always has this bit set.
- R5: Throttling gates loads only. A ready warp whose `next_is_load` bit is 0 is eligible even when its `load_allowed` bit is 0. A ready warp whose `next_is_load` bit is 1 is eligible only if its `load_allowed` bit is 1.
- R6: `issue_grant` has at most one bit set, and only for an eligible warp. It is zero only when no warp is eligible.
- R7: The grant goes to the first eligible warp found by scanning upward from the pointer and wrapping around. After a grant to warp g the pointer moves to (g+1) mod NUM_WARPS. Without a grant the pointer stays where it is.
- R8: After reset, all scores are 0, all victim stores are empty and the pointer is 0. As a result `load_allowed` is all ones.
- R9: When an eviction and a miss for the same warp arrive in the same cycle, the miss is looked up against the store contents from before that eviction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| evict_valid | input | 1 | An L1 line owned by `evict_warp` was evicted this cycle |
| evict_warp | input | $clog2(NUM_WARPS) | Warp on whose behalf the line was evicted |
| evict_tag | input | TAG_W | Tag of the evicted line |
| miss_valid | input | 1 | `miss_warp` missed in the L1 this cycle |
| miss_warp | input | $clog2(NUM_WARPS) | Warp that missed |
| miss_tag | input | TAG_W | Tag of the missing line |
| warp_ready | input | NUM_WARPS | Warp has an instruction ready to issue |
| next_is_load | input | NUM_WARPS | The ready instruction of that warp is a load |
| issue_grant | output | NUM_WARPS | One-hot issue grant, or zero |
| load_allowed | output | NUM_WARPS | Warp is currently under the load cap |

## Verification
The assertions assume that `evict_warp` and `miss_warp` hold valid warp indices whenever their valid bits are set. They also assume that `warp_ready` and `next_is_load` are settled before the clock edge, because grant and load cap are combinational on the current inputs and the registered scores. The stimulus uses only indices below NUM_WARPS and changes inputs only at the falling edge. Directed phases build scores past the cutoff, let them decay across it, and saturate one warp. A long random phase draws tags from a small pool, so that victim hits are frequent enough to move the load cap back and forth.

// File: rtl/wts_pkg.sv
package wts_pkg;

   // next index of a ring of n slots
   function automatic int ring_next(input int idx, input int n);
      return (idx + 1 >= n) ? 0 : idx + 1;
   endfunction

   // default sizes shared by the block and its bench
   localparam int DEF_WARPS    = 8;
   localparam int DEF_VT_DEPTH = 4;
   localparam int DEF_TAG_W    = 16;
   localparam int DEF_SCORE_W  = 10;
   localparam int DEF_BONUS    = 32;
   localparam int DEF_CUTOFF   = 256;

endpackage

// File: rtl/wts_victim_tags.sv
module wts_victim_tags #(
   parameter int DEPTH = 4,
   parameter int TAG_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             evict_en,
   input  logic [TAG_W-1:0] evict_tag,
   input  logic             lookup_en,
   input  logic [TAG_W-1:0] lookup_tag,
   output logic             hit
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("wts_victim_tags: DEPTH must be at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("wts_victim_tags: TAG_W must be positive");
   end

   logic [TAG_W-1:0] tag_q [DEPTH];
   logic [DEPTH-1:0] vld_q;
   logic [DEPTH-1:0] match;

   // valid bits shift in from slot 0 (youngest) toward DEPTH-1 (oldest)
   always_ff @(posedge clk) begin
      if (rst)
         vld_q <= '0;
      else if (evict_en)
         vld_q <= {vld_q[DEPTH-2:0], 1'b1};
   end

   for (genvar k = 0; k < DEPTH; k++) begin : g_slot
      if (k == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (evict_en)
               tag_q[k] <= evict_tag;
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (evict_en)
               tag_q[k] <= tag_q[k-1];
         end
      end
      assign match[k] = vld_q[k] && (tag_q[k] == lookup_tag);
   end

   // lookup sees the registered contents: an eviction in the same cycle is not yet visible (R9)
   assign hit = lookup_en && (|match);

   // a hit is only possible once something was recorded since reset (R1)
   p_hit_needs_entry_r1 : assert property (@(posedge clk) disable iff (rst)
      hit |-> (vld_q != '0));

endmodule

// File: rtl/wts_score.sv
module wts_score #(
   parameter int SCORE_W = 10,
   parameter int BONUS   = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               hit,
   output logic [SCORE_W-1:0] score
);

   localparam int unsigned MAXV = (1 << SCORE_W) - 1;
   localparam logic [SCORE_W:0] BONUS_V = (SCORE_W + 1)'(BONUS);
   localparam logic [SCORE_W:0] MAX_V   = (SCORE_W + 1)'(MAXV);

   if (SCORE_W < 2 || SCORE_W > 20) begin : g_bad_width
      $error("wts_score: SCORE_W out of range");
   end
   if (BONUS < 1 || BONUS >= int'(MAXV)) begin : g_bad_bonus
      $error("wts_score: BONUS must lie between 1 and the score maximum");
   end

   logic [SCORE_W-1:0] score_q;
   logic [SCORE_W-1:0] dec;
   logic [SCORE_W:0]   sum;
   logic [SCORE_W-1:0] score_d;

   always_comb begin
      dec     = (score_q == '0) ? '0 : score_q - 1'b1;
      sum     = {1'b0, dec} + (hit ? BONUS_V : '0);
      score_d = (sum > MAX_V) ? MAX_V[SCORE_W-1:0] : sum[SCORE_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst)
         score_q <= '0;
      else
         score_q <= score_d;
   end

   assign score = score_q;

   // without a hit the score falls by exactly one (R3)
   p_decay_step_r3 : assert property (@(posedge clk) disable iff (rst)
      (!hit && score_q != '0) |=> (score_q == $past(score_q) - 1'b1));

   // a score at zero stays at zero without a hit (R3)
   p_floor_r3 : assert property (@(posedge clk) disable iff (rst)
      (!hit && score_q == '0) |=> (score_q == '0));

   // a hit never lowers a score (R2)
   p_hit_raises_r2 : assert property (@(posedge clk) disable iff (rst)
      hit |=> (score_q >= $past(score_q)));

endmodule

// File: rtl/wts_load_cap.sv
module wts_load_cap #(
   parameter int NUM_WARPS = 8,
   parameter int SCORE_W   = 10,
   parameter int CUTOFF    = 256
) (
   input  logic [NUM_WARPS-1:0][SCORE_W-1:0] scores,
   output logic [NUM_WARPS-1:0]              load_ok
);

   localparam int SUM_W = SCORE_W + $clog2(NUM_WARPS) + 1;

   if (CUTOFF < 1) begin : g_bad_cutoff
      $error("wts_load_cap: CUTOFF must be positive");
   end

   for (genvar i = 0; i < NUM_WARPS; i++) begin : g_warp
      logic [SUM_W-1:0] ahead;
      always_comb begin
         ahead = '0;
         for (int j = 0; j < NUM_WARPS; j++) begin
            if (j != i) begin
               if ((scores[j] > scores[i]) || ((scores[j] == scores[i]) && (j < i)))
                  ahead = ahead + SUM_W'(scores[j]);
            end
         end
         load_ok[i] = (int'(ahead) < CUTOFF);
      end
   end

   // the top-ranked warp always keeps its loads (R4)
   p_top_allowed_r4 : assert final (load_ok != '0);

endmodule

// File: rtl/wts_rr_arb.sv
module wts_rr_arb #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);

   import wts_pkg::*;

   localparam int IW = (N > 1) ? $clog2(N) : 1;

   logic [IW-1:0] ptr_q;
   logic [IW-1:0] sel;
   logic          found;
   int            idx;

   always_comb begin
      gnt   = '0;
      found = 1'b0;
      sel   = ptr_q;
      idx   = 0;
      for (int k = 0; k < N; k++) begin
         idx = (int'(ptr_q) + k) % N;
         if (!found && req[idx]) begin
            found = 1'b1;
            sel   = IW'(idx);
         end
      end
      if (found)
         gnt[sel] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst)
         ptr_q <= '0;
      else if (found)
         ptr_q <= IW'(ring_next(int'(sel), N));
   end

   p_grant_onehot_r6 : assert property (@(posedge clk) disable iff (rst)
      $onehot0(gnt));

   p_grant_subset_r6 : assert property (@(posedge clk) disable iff (rst)
      (gnt & ~req) == '0);

   p_no_idle_r6 : assert property (@(posedge clk) disable iff (rst)
      (req != '0) |-> (gnt != '0));

   // the warp just granted loses priority to any other requester next cycle (R7)
   p_rotate_r7 : assert property (@(posedge clk) disable iff (rst)
      ((gnt != '0) && ((req & ~gnt) != '0)) |=> ((gnt & $past(gnt)) == '0 || (req & ~gnt) == '0));

endmodule

// File: rtl/warp_throttle_sched.sv
module warp_throttle_sched #(
   parameter int NUM_WARPS = wts_pkg::DEF_WARPS,
   parameter int VT_DEPTH  = wts_pkg::DEF_VT_DEPTH,
   parameter int TAG_W     = wts_pkg::DEF_TAG_W,
   parameter int SCORE_W   = wts_pkg::DEF_SCORE_W,
   parameter int BONUS     = wts_pkg::DEF_BONUS,
   parameter int CUTOFF    = wts_pkg::DEF_CUTOFF
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         evict_valid,
   input  logic [$clog2(NUM_WARPS)-1:0] evict_warp,
   input  logic [TAG_W-1:0]             evict_tag,
   input  logic                         miss_valid,
   input  logic [$clog2(NUM_WARPS)-1:0] miss_warp,
   input  logic [TAG_W-1:0]             miss_tag,
   input  logic [NUM_WARPS-1:0]         warp_ready,
   input  logic [NUM_WARPS-1:0]         next_is_load,
   output logic [NUM_WARPS-1:0]         issue_grant,
   output logic [NUM_WARPS-1:0]         load_allowed
);

   localparam int WID_W = $clog2(NUM_WARPS);

   if (NUM_WARPS < 2 || NUM_WARPS > 64) begin : g_bad_warps
      $error("warp_throttle_sched: NUM_WARPS out of range");
   end

   logic [NUM_WARPS-1:0]              vhit;
   logic [NUM_WARPS-1:0][SCORE_W-1:0] scores;
   logic [NUM_WARPS-1:0]              eligible;

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
      logic ev_here;
      logic miss_here;
      assign ev_here   = evict_valid && (evict_warp == WID_W'(w));
      assign miss_here = miss_valid && (miss_warp == WID_W'(w));

      wts_victim_tags #(.DEPTH(VT_DEPTH), .TAG_W(TAG_W)) u_vt (
         .clk        (clk),
         .rst        (rst),
         .evict_en   (ev_here),
         .evict_tag  (evict_tag),
         .lookup_en  (miss_here),
         .lookup_tag (miss_tag),
         .hit        (vhit[w])
      );

      wts_score #(.SCORE_W(SCORE_W), .BONUS(BONUS)) u_score (
         .clk   (clk),
         .rst   (rst),
         .hit   (vhit[w]),
         .score (scores[w])
      );
   end

   wts_load_cap #(.NUM_WARPS(NUM_WARPS), .SCORE_W(SCORE_W), .CUTOFF(CUTOFF)) u_cap (
      .scores  (scores),
      .load_ok (load_allowed)
   );

   assign eligible = warp_ready & (~next_is_load | load_allowed);

   wts_rr_arb #(.N(NUM_WARPS)) u_arb (
      .clk (clk),
      .rst (rst),
      .req (eligible),
      .gnt (issue_grant)
   );

   // a load is never granted to a warp past the cap (R5)
   p_load_gate_r5 : assert property (@(posedge clk) disable iff (rst)
      (issue_grant & next_is_load & ~load_allowed) == '0);

   // victim hits come only from the warp that missed (R2)
   p_hit_owner_r2 : assert property (@(posedge clk) disable iff (rst)
      $countones(vhit) <= 1);

   // a ready non-load warp is never starved by throttling alone (R5)
   p_nonload_served_r5 : assert property (@(posedge clk) disable iff (rst)
      ((warp_ready & ~next_is_load) != '0) |-> (issue_grant != '0));

endmodule

// File: tb/warp_throttle_sched_test.sv
module warp_throttle_sched_test;

   localparam int CLK_PERIOD = 10;
   localparam int NW     = 8;
   localparam int DEPTH  = 4;
   localparam int MAXS   = 1023;
   localparam int BON    = 32;
   localparam int CUT    = 256;
   localparam int WDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        evict_valid = 1'b0;
   logic [2:0]  evict_warp = '0;
   logic [15:0] evict_tag = '0;
   logic        miss_valid = 1'b0;
   logic [2:0]  miss_warp = '0;
   logic [15:0] miss_tag = '0;
   logic [7:0]  warp_ready = '0;
   logic [7:0]  next_is_load = '0;
   logic [7:0]  issue_grant;
   logic [7:0]  load_allowed;

   always #(CLK_PERIOD / 2) clk = ~clk;

   warp_throttle_sched uut (
      .clk          (clk),
      .rst          (rst),
      .evict_valid  (evict_valid),
      .evict_warp   (evict_warp),
      .evict_tag    (evict_tag),
      .miss_valid   (miss_valid),
      .miss_warp    (miss_warp),
      .miss_tag     (miss_tag),
      .warp_ready   (warp_ready),
      .next_is_load (next_is_load),
      .issue_grant  (issue_grant),
      .load_allowed (load_allowed)
   );

   // reference model state
   int          m_score [NW];
   logic [15:0] m_vq [NW][$];
   int          m_ptr;
   int          total = 0;
   int          bad   = 0;
   int          cycles = 0;
   bit          done  = 0;
   string       cur_req = "R8";

   function automatic bit m_holds(input int w, input logic [15:0] t);
      foreach (m_vq[w][k])
         if (m_vq[w][k] == t) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic [7:0] m_load_ok();
      logic [7:0] r;
      for (int i = 0; i < NW; i++) begin
         int ahead = 0;
         for (int j = 0; j < NW; j++)
            if (j != i && (m_score[j] > m_score[i] || (m_score[j] == m_score[i] && j < i)))
               ahead += m_score[j];
         r[i] = (ahead < CUT);
      end
      return r;
   endfunction

   task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s at cycle %0d: actual=%b expected=%b", req, what, cycles, act, exp);
      end
   endtask

   task automatic step(input logic ev, input int ew, input logic [15:0] et,
                       input logic mv, input int mw, input logic [15:0] mt,
                       input logic [7:0] rdy, input logic [7:0] ld);
      logic [7:0] exp_ok;
      logic [7:0] exp_gnt;
      logic [7:0] elig;
      int         g;
      bit         hit;
      evict_valid  = ev;  evict_warp = 3'(ew); evict_tag = et;
      miss_valid   = mv;  miss_warp  = 3'(mw); miss_tag  = mt;
      warp_ready   = rdy; next_is_load = ld;
      #2;
      exp_ok  = m_load_ok();
      elig    = rdy & (~ld | exp_ok);
      exp_gnt = '0;
      g       = -1;
      for (int k = 0; k < NW; k++) begin
         int idx = (m_ptr + k) % NW;
         if (g < 0 && elig[idx]) g = idx;
      end
      if (g >= 0) exp_gnt[g] = 1'b1;
      check(cur_req, "load_allowed (R4)", load_allowed, exp_ok);
      check(cur_req, "issue_grant (R6 R7)", issue_grant, exp_gnt);
      @(posedge clk);
      #1;
      cycles++;
      hit = mv && m_holds(mw, mt);
      for (int w = 0; w < NW; w++) begin
         int s = (m_score[w] > 0) ? m_score[w] - 1 : 0;
         if (hit && w == mw) s += BON;
         m_score[w] = (s > MAXS) ? MAXS : s;
      end
      if (ev) begin
         m_vq[ew].push_front(et);
         if (m_vq[ew].size() > DEPTH) void'(m_vq[ew].pop_back());
      end
      if (g >= 0) m_ptr = (g + 1) % NW;
      @(negedge clk);
   endtask

   task automatic idle(input int n, input logic [7:0] rdy, input logic [7:0] ld);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, rdy, ld);
   endtask

   initial begin : watchdog
      for (int i = 0; i < WDOG; i++) begin
         @(posedge clk);
         if (done) disable watchdog;
      end
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      for (int w = 0; w < NW; w++) m_score[w] = 0;
      m_ptr = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #2;
      // R8: reset state, all warps under the cap, nothing granted while idle
      check("R8", "load_allowed after reset", load_allowed, 8'hFF);
      check("R8", "issue_grant idle", issue_grant, 8'h00);
      @(negedge clk);
      cur_req = "R8";
      idle(4, 8'hFF, 8'hFF);

      // R1: five evictions into a 4-deep store drop the oldest tag
      cur_req = "R1";
      for (int t = 0; t < 5; t++) step(1, 2, 16'h0100 + 16'(t), 0, 0, 0, 8'hFF, 8'hFF);
      for (int i = 0; i < 10; i++) step(0, 0, 0, 1, 2, 16'h0100, 8'hFF, 8'hFF);
      check("R1", "no throttling from dropped tag", load_allowed, 8'hFF);
      for (int i = 0; i < 10; i++) step(0, 0, 0, 1, 2, 16'h0104, 8'hFF, 8'hFF);
      check("R1", "warp 2 alone allowed after repeated hits", load_allowed, 8'h04);

      // R3: decay down across the cutoff
      cur_req = "R3";
      idle(400, 8'hFF, 8'hFF);
      check("R3", "all allowed after decay", load_allowed, 8'hFF);

      // R2: another warp's miss on the same tag is ignored, then the owner hits
      cur_req = "R2";
      step(1, 3, 16'h0200, 0, 0, 0, 8'hFF, 8'hFF);
      for (int i = 0; i < 12; i++) step(0, 0, 0, 1, 5, 16'h0200, 8'hFF, 8'hFF);
      check("R2", "foreign miss has no effect", load_allowed, 8'hFF);
      for (int i = 0; i < 12; i++) step(0, 0, 0, 1, 3, 16'h0200, 8'hFF, 8'hFF);
      check("R2", "owner hits throttle others", load_allowed, 8'h08);

      // R5: throttled warps still issue non-load work
      cur_req = "R5";
      for (int i = 0; i < 16; i++) step(0, 0, 0, 0, 0, 0, 8'hF7, 8'h0F);
      idle(400, 8'hFF, 8'hFF);

      // R4: two ranked warps, the second still under the cutoff
      cur_req = "R4";
      step(1, 6, 16'h0600, 1, 0, 0, 8'hFF, 8'hFF);
      step(1, 1, 16'h0110, 0, 0, 0, 8'hFF, 8'hFF);
      for (int i = 0; i < 5; i++) begin
         step(0, 0, 0, 1, 6, 16'h0600, 8'hFF, 8'hFF);
         if (i < 4) step(0, 0, 0, 1, 1, 16'h0110, 8'hFF, 8'hFF);
      end
      check("R4", "top two allowed", load_allowed, 8'h42);
      idle(300, 8'hAA, 8'hFF);

      // R9: eviction and miss to the same tag in one cycle do not hit
      cur_req = "R9";
      for (int i = 0; i < 12; i++) step(1, 4, 16'h0400 + 16'(i), 1, 4, 16'h0400 + 16'(i), 8'hFF, 8'hFF);
      check("R9", "no hit on same-cycle eviction", load_allowed, 8'hFF);

      // R2: saturation at the score maximum
      cur_req = "R2";
      step(1, 7, 16'h0700, 0, 0, 0, 8'hFF, 8'hFF);
      for (int i = 0; i < 40; i++) step(0, 0, 0, 1, 7, 16'h0700, 8'hFF, 8'hFF);
      cur_req = "R3";
      idle(1100, 8'hFF, 8'hFF);

      // R7: random traffic from a small tag pool
      cur_req = "R7";
      for (int i = 0; i < 4000; i++) begin
         logic        ev = ($urandom % 2) == 0;
         logic        mv = ($urandom % 4) != 0;
         int          ew = $urandom % NW;
         int          mw = (i % 600 < 300) ? ($urandom % 3) : ($urandom % NW);
         logic [15:0] et = 16'($urandom % 6);
         logic [15:0] mt = 16'($urandom % 6);
         step(ev, ew, et, mv, mw, mt, 8'($urandom), 8'($urandom));
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule